// File: doc/BRIEF.md
# Prescaler Timer with Watchdog

The block is a free-running binary counter that advances on every oscillator clock. Its upper bits provide pulse waveforms whose periods range from 2^10 to 2^15 clocks. A 4-bit control register, which software can only write, sets how the counter is read back.

The control register has two readback modes:

- **Tap mode** returns four raw counter taps.
- **Pulse mode** returns one pulse that a 3-bit code selects. The code fixes both the period and a duty of 50% or 75%.

In both modes the readback is the bitwise complement of the counter-derived bits. As a result, a freshly cleared counter reads as ones.

A clear strobe or a hold-release event zeroes the counter. When watchdog mode is enabled and the counter runs through its full 2^16-clock span without being cleared, the block raises a reset request for a single cycle.

Top module: `presc_timer`

## Requirements
- R1: After reset the control register is 0000 and the counter is 0. In that state `rd_val` is 4'b1000, `pulse` is 0 and `wd_rst` is 0.
- R2: The counter increments by one on every clock that has neither a clear nor a release. With control bit 3 = 1, `rd_val[3:0]` equals the complement of counter bits {14,13,12,11}.
- R3: With control bit 3 = 0, `rd_val[3]` is the complement of `pulse` and `rd_val[2:0]` is 000.
- R4: Control bits 2:0 select `pulse` from counter bits. A 50% pulse of period 2^n is bit n-1, and a 75% pulse is bit n-1 OR bit n-2. The codes are:
  - 0: period 2^10, 50%
  - 1: period 2^11, 50%
  - 2: period 2^11, 75%
  - 3: period 2^12, 50%
  - 4: period 2^12, 75%
  - 5: period 2^13, 50%
  - 6: period 2^13, 75%
  - 7: period 2^14, 50%
- R5: A clear strobe makes the counter 0 in the following cycle.
- R6: A hold-release event makes the counter 0 in the following cycle.
- R7: With `wd_en` = 1, the counter passing from all ones to zero without a clear or release raises `wd_rst` for exactly one cycle, in the cycle after the wrap edge.
- R8: With `wd_en` = 0, `wd_rst` stays 0 even when the counter wraps.
- R9: A control write takes effect on the readback and pulse in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Asynchronous reset, active high |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 4 | Control write data: bit 3 selects the mode, bits 2:0 select the period and duty |
| tmr_clr | input | 1 | Counter clear strobe |
| hold_rel | input | 1 | Hold-release event; clears the counter |
| wd_en | input | 1 | Watchdog enable |
| rd_val | output | 4 | Complemented readback |
| pulse | output | 1 | Selected pulse (true polarity) |
| wd_rst | output | 1 | Watchdog reset request, one cycle wide |

## Verification
The bench goes after the wrap of the full 16-bit span in three situations: with the watchdog enabled, with it disabled, and interleaved with random control writes.

- A design that compared against the wrong terminal count would fire early or never.
- A design that held the request level would show a pulse wider than one cycle.
- A design that ignored `wd_en` would fire in the disabled span.

All eight period/duty codes and both readback modes are checked against a model on every cycle. Swapped tap indices or a missing OR on the 75% codes would therefore show up as a mismatched pulse or readback. Random clears and hold-release events catch a counter that keeps its count or skips one increment after the strobe.

// File: rtl/presc_timer.sv
module presc_timer #(
  parameter int CNT_W    = 16,
  parameter int TAP_BASE = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [3:0] ctl_data,
  input  logic       tmr_clr,
  input  logic       hold_rel,
  input  logic       wd_en,
  output logic [3:0] rd_val,
  output logic       pulse,
  output logic       wd_rst
);
  localparam int B0 = TAP_BASE - 1;
  localparam int B1 = TAP_BASE;
  localparam int B2 = TAP_BASE + 1;
  localparam int B3 = TAP_BASE + 2;
  localparam int B4 = TAP_BASE + 3;
  localparam int RD_HI = CNT_W - 2;

  logic [CNT_W-1:0] cnt;
  logic [3:0]       ctl;
  logic             zap;
  logic             at_top;

  assign zap    = tmr_clr | hold_rel;
  assign at_top = &cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt    <= '0;
      ctl    <= 4'b0000;
      wd_rst <= 1'b0;
    end else begin
      cnt    <= zap ? '0 : cnt + 1'b1;
      wd_rst <= wd_en & ~zap & at_top;
      if (ctl_wr) ctl <= ctl_data;
    end
  end

  always_comb begin
    case (ctl[2:0])
      3'd0:    pulse = cnt[B0];
      3'd1:    pulse = cnt[B1];
      3'd2:    pulse = cnt[B1] | cnt[B0];
      3'd3:    pulse = cnt[B2];
      3'd4:    pulse = cnt[B2] | cnt[B1];
      3'd5:    pulse = cnt[B3];
      3'd6:    pulse = cnt[B3] | cnt[B2];
      default: pulse = cnt[B4];
    endcase
  end

  assign rd_val = ctl[3] ? ~cnt[RD_HI -: 4] : {~pulse, 3'b000};

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_clr |=> cnt == '0);
  // R6
  rel_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hold_rel |=> cnt == '0);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !zap |=> cnt == $past(cnt) + 1'b1);
  // R7
  wd_single_chk: assert property (@(posedge clk) disable iff (rst)
    wd_rst |=> !wd_rst);
  // R7
  wd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wd_rst |-> cnt == '0);
  // R8
  wd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_rst) |-> $past(wd_en));
endmodule

// File: tb/sim_presc_timer.sv
module sim_presc_timer;
  logic clk = 0, rst = 1;
  logic ctl_wr = 0, tmr_clr = 0, hold_rel = 0, wd_en = 0;
  logic [3:0] ctl_data = 0;
  logic [3:0] rd_val;
  logic pulse, wd_rst;
  int n_chk = 0, n_bad = 0, wd_seen = 0;
  logic [15:0] m_cnt;
  logic [3:0]  m_ctl;
  logic        m_wd;

  always #5 clk = ~clk;

  presc_timer u0 (.clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .tmr_clr(tmr_clr), .hold_rel(hold_rel), .wd_en(wd_en),
    .rd_val(rd_val), .pulse(pulse), .wd_rst(wd_rst));

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_cnt <= 0; m_ctl <= 0; m_wd <= 0;
    end else begin
      m_cnt <= (tmr_clr | hold_rel) ? 16'd0 : m_cnt + 16'd1;
      m_wd  <= wd_en & ~tmr_clr & ~hold_rel & (m_cnt == 16'hFFFF);
      if (ctl_wr) m_ctl <= ctl_data;
    end
  end

  function automatic bit exp_pulse(logic [15:0] c, logic [2:0] s);
    case (s)
      3'd0: return c[9];
      3'd1: return c[10];
      3'd2: return c[10] | c[9];
      3'd3: return c[11];
      3'd4: return c[11] | c[10];
      3'd5: return c[12];
      3'd6: return c[12] | c[11];
      default: return c[13];
    endcase
  endfunction

  function automatic logic [3:0] exp_rd(logic [15:0] c, logic [3:0] k);
    if (k[3]) return ~c[14:11];
    return {~exp_pulse(c, k[2:0]), 3'b000};
  endfunction

  task automatic check(input string tag);
    logic [3:0] er;
    logic ep;
    er = exp_rd(m_cnt, m_ctl);
    ep = exp_pulse(m_cnt, m_ctl[2:0]);
    n_chk++;
    if (rd_val !== er || pulse !== ep || wd_rst !== m_wd) begin
      n_bad++;
      $display("FAIL %s: rd=%b pulse=%b wd=%b expected rd=%b pulse=%b wd=%b",
               tag, rd_val, pulse, wd_rst, er, ep, m_wd);
    end
    if (wd_rst === 1'b1) wd_seen++;
  endtask

  task automatic step(input bit c, input bit r, input bit w, input logic [3:0] d,
                      input string tag);
    tmr_clr = c; hold_rel = r; ctl_wr = w; ctl_data = d;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic run_free(input int cyc, input string tag);
    for (int i = 0; i < cyc; i++) begin
      bit w;
      w = ($urandom % 64) == 0;
      step(0, 0, w, 4'($urandom), w ? "R9" : tag);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed1);
    repeat (2) @(negedge clk);
    // R1
    n_chk++;
    if (rd_val !== 4'b1000 || pulse !== 1'b0 || wd_rst !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: rd=%b pulse=%b wd=%b expected rd=1000 pulse=0 wd=0", rd_val, pulse, wd_rst);
    end
    rst = 0;
    @(negedge clk);
    check("R1");
    // R4 R3: every code, directed
    for (int k = 0; k < 8; k++) begin
      step(1, 0, 1, 4'(k), "R5");
      for (int j = 0; j < 3000; j++) step(0, 0, 0, 4'(k), "R4");
    end
    // R2 tap mode, directed
    step(0, 1, 1, 4'b1000, "R6");
    for (int j = 0; j < 100; j++) step(0, 0, 0, 4'b1000, "R2");
    // R7: watchdog on, free run across the wrap
    step(1, 0, 0, 4'b0000, "R5");
    wd_en = 1;
    wd_seen = 0;
    run_free(65600, "R7");
    n_chk++;
    if (wd_seen != 1) begin
      n_bad++;
      $display("FAIL R7: watchdog pulses=%0d expected 1", wd_seen);
    end
    // R8: watchdog off across the next wrap
    wd_en = 0;
    wd_seen = 0;
    run_free(65600, "R8");
    n_chk++;
    if (wd_seen != 0) begin
      n_bad++;
      $display("FAIL R8: watchdog pulses=%0d expected 0", wd_seen);
    end
    // random clears and releases
    for (int i = 0; i < 4000; i++) begin
      bit c, r, w;
      c = ($urandom % 300) == 0;
      r = ($urandom % 300) == 0;
      w = ($urandom % 50) == 0;
      step(c, r, w, 4'($urandom), r ? "R6" : (c ? "R5" : (w ? "R9" : "R3")));
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1900000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule